// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register

This block holds the basic mode-control word of a tri-speed Ethernet transceiver and a small event-status word, both reached through a plain register port (address, write data, write strobe, read strobe, read data). It drives a resolved link speed and duplex, a loopback enable and a one-cycle soft-reset pulse to the rest of the transceiver.

Power-on defaults come from two strap inputs. The block samples them on the first clock after the asynchronous reset is released and keeps them for every later soft reset. A soft reset is started by writing the reset bit. The bit keeps reading as 1 through a timed window of `RST_CYCLES` clocks. It then stays at 1 until the link logic reports, on `mode_ready_i`, that negotiation has started or the forced mode is up. Only then does it clear itself.

When negotiation is enabled, the output speed and duplex follow the negotiated result on `an_spd_i` and `an_fdx_i`. When negotiation is disabled, they follow the forced bits in the control word. The status word has two kinds of bits. Latch-high bits hold a 1 after their event until the status word is read. Latch-low bits hold a 0 after their condition drops until the status word is read.

Top module: `phy_ctrl_regs`

## Requirements
- R1: Control word layout (address 0): bit 15 reset busy, bit 14 loopback, bit 13 speed low, bit 12 negotiation enable, bit 8 full duplex, bit 6 speed high. After reset the word reads negotiation enable = `strap_an_i`, speed low = `strap_spd_i & ~strap_an_i`, speed high = 0, full duplex = 1, loopback = 0, busy = 0. With straps an=0 and spd=1 this reads 0x2100. Soft resets reuse the straps sampled at power-on, not the live straps.
- R2: Writing 1 to bit 15 while no reset is running has three effects. `soft_rst_o` is high for exactly one cycle. Bit 15 reads 1. Every control field returns to its default, including loopback, whatever else the written data contained.
- R3: Bit 15 stays 1 for at least `RST_CYCLES` cycles after the start. After that it clears on the first edge at which `mode_ready_i` is 1, and never while `mode_ready_i` is 0.
- R4: Writes to the control word are ignored while bit 15 reads 1.
- R5: `loopback_o` equals control bit 14.
- R6: While bit 12 is 1, `speed_o` and `full_dup_o` follow `an_spd_i` and `an_fdx_i` one cycle later, and bits 6, 8 and 13 have no effect on them.
- R7: While bit 12 is 0, `speed_o` = {bit 6, bit 13} one cycle after the control word changes (00 = 10 Mb/s, 01 = 100 Mb/s, 10 = 1000 Mb/s), and `full_dup_o` = bit 8.
- R8: When the selected speed code is 11 (reserved), `speed_o` and `full_dup_o` keep their previous values and `spd_err_o` is 1. Otherwise `spd_err_o` is 0, and `speed_o` never shows 11.
- R9: Status word (address 1) bits [N_LH-1:0] are latch-high. A 1 on `lh_evt_i[i]` in any cycle makes the bit read 1 until a status read. After the read it shows the live event. An event in the same cycle as the read is kept for the next read.
- R10: Status bits [N_LH+N_LL-1:N_LH] are latch-low. A 0 on `ll_cond_i[i]` makes the bit read 0 until a status read. After the read it shows the live condition. A drop in the same cycle as the read is kept for the next read. These bits read 1 after reset.
- R11: Control bits other than those in R1 read 0 and ignore writes. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 16 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe (status read clears latches) |
| rdata_o | output | 16 | Read data, combinational from address |
| strap_an_i | input | 1 | Strap: negotiation enable default |
| strap_spd_i | input | 1 | Strap: speed-low default when negotiation is off |
| mode_ready_i | input | 1 | Negotiation started or forced mode entered |
| an_spd_i | input | 2 | Negotiated speed code |
| an_fdx_i | input | 1 | Negotiated full duplex |
| lh_evt_i | input | N_LH | Latch-high event inputs |
| ll_cond_i | input | N_LL | Latch-low live conditions |
| speed_o | output | 2 | Resolved speed code |
| full_dup_o | output | 1 | Resolved full duplex |
| spd_err_o | output | 1 | Reserved speed code selected |
| loopback_o | output | 1 | Loopback enable |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |

## Verification
The bench builds the block with `RST_CYCLES` = 16, two latch-high bits and two latch-low bits. The short reset window makes it possible to probe the exact cycle at which bit 15 clears, both with `mode_ready_i` held high and with it held low well past the window. With two bits of each latch kind, one bit can see an isolated event while its neighbour sees an event in the same cycle as a read, and the read-back shows that each bit keeps its own history.

// File: rtl/phy_ctrl_pkg.sv
package phy_ctrl_pkg;

  typedef enum logic [1:0] {
    SPD_10   = 2'b00,
    SPD_100  = 2'b01,
    SPD_1000 = 2'b10,
    SPD_RSVD = 2'b11
  } spd_e;

  localparam int unsigned B_RST    = 15;
  localparam int unsigned B_LB     = 14;
  localparam int unsigned B_SPD_LO = 13;
  localparam int unsigned B_AN     = 12;
  localparam int unsigned B_DUP    = 8;
  localparam int unsigned B_SPD_HI = 6;

  typedef struct packed {
    logic lb;
    logic spd_lo;
    logic an_en;
    logic dup;
    logic spd_hi;
  } ctrl_t;

  function automatic ctrl_t ctrl_dflt(input logic an_s, input logic spd_s);
    ctrl_t c;
    c.lb     = 1'b0;
    c.an_en  = an_s;
    c.spd_lo = spd_s & ~an_s;
    c.spd_hi = 1'b0;
    c.dup    = 1'b1;
    return c;
  endfunction

  function automatic logic [15:0] ctrl_pack(input ctrl_t c, input logic busy);
    logic [15:0] w;
    w           = '0;
    w[B_RST]    = busy;
    w[B_LB]     = c.lb;
    w[B_SPD_LO] = c.spd_lo;
    w[B_AN]     = c.an_en;
    w[B_DUP]    = c.dup;
    w[B_SPD_HI] = c.spd_hi;
    return w;
  endfunction

endpackage

// File: rtl/phy_rst_seq.sv
module phy_rst_seq #(
  parameter int unsigned RST_CYCLES = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ready_i,
  output logic busy_o,
  output logic pulse_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] TERM = CW'(RST_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= start_i & ~busy_q;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q != TERM) cnt_q <= cnt_q + 1'b1;
        else if (ready_i)  busy_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/phy_evt_latch.sv
module phy_evt_latch #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cond_i,
  input  logic rd_i,
  output logic q_o
);
  logic q_q, q_d;

  generate
    if (ACTIVE_LOW) begin : g_low
      always_comb begin
        if (clr_i)     q_d = 1'b1;
        else if (rd_i) q_d = cond_i;
        else           q_d = q_q & cond_i;
      end
    end else begin : g_high
      always_comb begin
        if (clr_i) q_d = 1'b0;
        else       q_d = cond_i | (q_q & ~rd_i);
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= ACTIVE_LOW;
    else         q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/phy_speed_res.sv
module phy_speed_res
  import phy_ctrl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       an_en_i,
  input  logic [1:0] frc_spd_i,
  input  logic       frc_dup_i,
  input  logic [1:0] an_spd_i,
  input  logic       an_dup_i,
  output logic [1:0] spd_o,
  output logic       dup_o,
  output logic       err_o
);
  logic [1:0] cand_spd;
  logic       cand_dup;
  spd_e       spd_q;
  logic       dup_q, err_q;

  always_comb begin
    cand_spd = an_en_i ? an_spd_i : frc_spd_i;
    cand_dup = an_en_i ? an_dup_i : frc_dup_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spd_q <= SPD_10;
      dup_q <= 1'b0;
      err_q <= 1'b0;
    end else if (cand_spd == SPD_RSVD) begin
      err_q <= 1'b1;  // hold last legal mode
    end else begin
      spd_q <= spd_e'(cand_spd);
      dup_q <= cand_dup;
      err_q <= 1'b0;
    end
  end

  assign spd_o = spd_q;
  assign dup_o = dup_q;
  assign err_o = err_q;
endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned CTRL_ADDR  = 0,
  parameter int unsigned STAT_ADDR  = 1,
  parameter int unsigned RST_CYCLES = 60000,
  parameter int unsigned N_LH       = 2,
  parameter int unsigned N_LL       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [15:0]       wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [15:0]       rdata_o,
  input  logic              strap_an_i,
  input  logic              strap_spd_i,
  input  logic              mode_ready_i,
  input  logic [1:0]        an_spd_i,
  input  logic              an_fdx_i,
  input  logic [N_LH-1:0]   lh_evt_i,
  input  logic [N_LL-1:0]   ll_cond_i,
  output logic [1:0]        speed_o,
  output logic              full_dup_o,
  output logic              spd_err_o,
  output logic              loopback_o,
  output logic              soft_rst_o
);
  localparam int unsigned N_ST = N_LH + N_LL;

  logic        init_q;
  logic [1:0]  strap_q;
  ctrl_t       ctrl_q, ctrl_d;
  logic        rst_busy, rst_start;
  logic        hit_ctrl, hit_stat, wr_ctrl, rd_stat;
  logic [N_LH-1:0] lh_q;
  logic [N_LL-1:0] ll_q;
  logic [15:0] stat_w;

  assign hit_ctrl  = (addr_i == ADDR_W'(CTRL_ADDR));
  assign hit_stat  = (addr_i == ADDR_W'(STAT_ADDR));
  assign wr_ctrl   = we_i & hit_ctrl;
  assign rd_stat   = re_i & hit_stat;
  assign rst_start = wr_ctrl & wdata_i[B_RST] & ~rst_busy & init_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (!init_q) begin
      ctrl_d = ctrl_dflt(strap_an_i, strap_spd_i);
    end else if (rst_start) begin
      ctrl_d = ctrl_dflt(strap_q[1], strap_q[0]);
    end else if (wr_ctrl && !rst_busy) begin
      ctrl_d.lb     = wdata_i[B_LB];
      ctrl_d.spd_lo = wdata_i[B_SPD_LO];
      ctrl_d.an_en  = wdata_i[B_AN];
      ctrl_d.dup    = wdata_i[B_DUP];
      ctrl_d.spd_hi = wdata_i[B_SPD_HI];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q  <= 1'b0;
      strap_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (!init_q) begin
        init_q  <= 1'b1;
        strap_q <= {strap_an_i, strap_spd_i};
      end
      ctrl_q <= ctrl_d;
    end
  end

  phy_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (rst_start),
    .ready_i (mode_ready_i),
    .busy_o  (rst_busy),
    .pulse_o (soft_rst_o)
  );

  phy_speed_res u_speed_res (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .an_en_i   (ctrl_q.an_en),
    .frc_spd_i ({ctrl_q.spd_hi, ctrl_q.spd_lo}),
    .frc_dup_i (ctrl_q.dup),
    .an_spd_i  (an_spd_i),
    .an_dup_i  (an_fdx_i),
    .spd_o     (speed_o),
    .dup_o     (full_dup_o),
    .err_o     (spd_err_o)
  );

  generate
    for (genvar i = 0; i < N_LH; i++) begin : g_lh
      phy_evt_latch #(.ACTIVE_LOW(1'b0)) u_lat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (rst_start),
        .cond_i (lh_evt_i[i]),
        .rd_i   (rd_stat),
        .q_o    (lh_q[i])
      );
    end
    for (genvar j = 0; j < N_LL; j++) begin : g_ll
      phy_evt_latch #(.ACTIVE_LOW(1'b1)) u_lat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (rst_start),
        .cond_i (ll_cond_i[j]),
        .rd_i   (rd_stat),
        .q_o    (ll_q[j])
      );
    end
  endgenerate

  always_comb begin
    stat_w              = '0;
    stat_w[N_LH-1:0]    = lh_q;
    stat_w[N_ST-1:N_LH] = ll_q;
  end

  always_comb begin
    if (hit_ctrl)      rdata_o = ctrl_pack(ctrl_q, rst_busy);
    else if (hit_stat) rdata_o = stat_w;
    else               rdata_o = '0;
  end

  assign loopback_o = ctrl_q.lb;
endmodule

// File: rtl/phy_ctrl_regs_chk.sv
module phy_ctrl_regs_chk #(
  parameter int unsigned RST_CYCLES = 60000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       busy_i,
  input logic       ready_i,
  input logic [1:0] speed_i,
  input logic       dup_i,
  input logic       err_i
);
  int unsigned bcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bcnt_q <= 0;
    else if (busy_i) bcnt_q <= (bcnt_q == 32'hFFFF_FFFF) ? bcnt_q : bcnt_q + 1;
    else             bcnt_q <= 0;
  end

  // R2
  pulse_with_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |-> busy_i);

  // R2
  pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> !soft_rst_i);

  // R3
  rst_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> (bcnt_q >= RST_CYCLES));

  // R3
  rst_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> $past(ready_i));

  // R8
  rsvd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> ($stable(speed_i) && $stable(dup_i)));

  // R8
  speed_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_i != 2'b11);
endmodule

bind phy_ctrl_regs phy_ctrl_regs_chk #(.RST_CYCLES(RST_CYCLES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .soft_rst_i (soft_rst_o),
  .busy_i     (rst_busy),
  .ready_i    (mode_ready_i),
  .speed_i    (speed_o),
  .dup_i      (full_dup_o),
  .err_i      (spd_err_o)
);

// File: tb/phy_ctrl_regs_tb.sv
module phy_ctrl_regs_tb;
  localparam int unsigned RSTC = 16;
  localparam int K_RD = 0, K_SPD = 1, K_DUP = 2, K_ERR = 3, K_LB = 4, K_SRST = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic        we_i = 1'b0, re_i = 1'b0;
  logic [15:0] rdata_o;
  logic        strap_an_i = 1'b0, strap_spd_i = 1'b1;
  logic        mode_ready_i = 1'b1;
  logic [1:0]  an_spd_i = 2'b00;
  logic        an_fdx_i = 1'b0;
  logic [1:0]  lh_evt_i = 2'b00;
  logic [1:0]  ll_cond_i = 2'b11;
  logic [1:0]  speed_o;
  logic        full_dup_o, spd_err_o, loopback_o, soft_rst_o;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  phy_ctrl_regs #(.RST_CYCLES(RSTC), .N_LH(2), .N_LL(2)) u_dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .re_i, .rdata_o,
    .strap_an_i, .strap_spd_i, .mode_ready_i, .an_spd_i, .an_fdx_i,
    .lh_evt_i, .ll_cond_i, .speed_o, .full_dup_o, .spd_err_o,
    .loopback_o, .soft_rst_o
  );

  // monitor: drains expectations 2 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #8;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_RD:    act = rdata_o;
          K_SPD:   act = {14'd0, speed_o};
          K_DUP:   act = {15'd0, full_dup_o};
          K_ERR:   act = {15'd0, spd_err_o};
          K_LB:    act = {15'd0, loopback_o};
          default: act = {15'd0, soft_rst_o};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=0x%04h expected=0x%04h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [15:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic cyc();
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1; re_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk_i);
    addr_i = a; we_i = 1'b0; re_i = 1'b1;
    push(K_RD, exp, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) cyc();
    // R1 defaults from straps
    rd(0, 16'h2100, "R1");
    push(K_SPD, 16'h0001, "R7");
    push(K_DUP, 16'h0001, "R7");
    push(K_LB, 16'h0000, "R5");
    push(K_SRST, 16'h0000, "R2");
    rd(1, 16'h000C, "R10");

    // R11 unused bits and addresses
    wr(0, 16'h20BF);
    rd(0, 16'h2000, "R11");
    rd(5, 16'h0000, "R11");

    // R5 / R7 forced 1000, half duplex, loopback
    wr(0, 16'h4040);
    cyc(); cyc();
    push(K_LB, 16'h0001, "R5");
    push(K_SPD, 16'h0002, "R7");
    push(K_DUP, 16'h0000, "R7");
    rd(0, 16'h4040, "R5");

    // R7 forced 10
    wr(0, 16'h0000);
    cyc(); cyc();
    push(K_SPD, 16'h0000, "R7");
    push(K_LB, 16'h0000, "R5");

    // R8 reserved forced code
    wr(0, 16'h2140);
    cyc(); cyc();
    push(K_SPD, 16'h0000, "R8");
    push(K_DUP, 16'h0000, "R8");
    push(K_ERR, 16'h0001, "R8");
    wr(0, 16'h2100);
    cyc(); cyc();
    push(K_SPD, 16'h0001, "R7");
    push(K_DUP, 16'h0001, "R7");
    push(K_ERR, 16'h0000, "R8");

    // R6 negotiation enabled
    an_spd_i = 2'b10; an_fdx_i = 1'b1;
    wr(0, 16'h3000);
    cyc(); cyc();
    push(K_SPD, 16'h0002, "R6");
    push(K_DUP, 16'h0001, "R6");
    wr(0, 16'h1040);
    cyc(); cyc();
    push(K_SPD, 16'h0002, "R6");
    push(K_DUP, 16'h0001, "R6");
    an_spd_i = 2'b11;
    cyc(); cyc();
    push(K_SPD, 16'h0002, "R8");
    push(K_ERR, 16'h0001, "R8");
    an_spd_i = 2'b01; an_fdx_i = 1'b0;
    cyc(); cyc();
    push(K_SPD, 16'h0001, "R6");
    push(K_DUP, 16'h0000, "R6");
    push(K_ERR, 16'h0000, "R8");

    // R9 latch-high
    cyc(); lh_evt_i = 2'b01;
    cyc(); lh_evt_i = 2'b00;
    cyc();
    rd(1, 16'h000D, "R9");
    rd(1, 16'h000C, "R9");
    rd(1, 16'h000C, "R9"); lh_evt_i = 2'b10;
    cyc(); lh_evt_i = 2'b00;
    rd(1, 16'h000E, "R9");
    rd(1, 16'h000C, "R9");

    // R10 latch-low
    cyc(); ll_cond_i = 2'b10;
    cyc(); ll_cond_i = 2'b11;
    rd(1, 16'h0008, "R10");
    rd(1, 16'h000C, "R10");
    rd(1, 16'h000C, "R10"); ll_cond_i = 2'b01;
    cyc(); ll_cond_i = 2'b11;
    rd(1, 16'h0004, "R10");
    rd(1, 16'h000C, "R10");

    // R2 / R4 / R3 soft reset, ready held low
    wr(0, 16'h4000);
    cyc();
    push(K_LB, 16'h0001, "R5");
    strap_an_i = 1'b1;
    mode_ready_i = 1'b0;
    wr(0, 16'hC000);
    cyc();
    push(K_SRST, 16'h0001, "R2");
    push(K_LB, 16'h0000, "R2");
    rd(0, 16'hA100, "R2");
    push(K_SRST, 16'h0000, "R2");
    wr(0, 16'h4000);
    cyc();
    rd(0, 16'hA100, "R4");
    push(K_LB, 16'h0000, "R4");
    repeat (30) cyc();
    rd(0, 16'hA100, "R3");
    mode_ready_i = 1'b1;
    cyc(); cyc();
    rd(0, 16'h2100, "R3");

    // R3 exact window with ready high
    wr(0, 16'h8000);
    repeat (15) cyc();
    rd(0, 16'hA100, "R3");
    rd(0, 16'h2100, "R3");

    cyc(); cyc();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule